// File: doc/BRIEF.md
# Real-Time Clock Interrupt Status Aggregator

This block collects the event sources of a real-time clock and turns them into one main status register and two active-low interrupt pins. Three sources arrive from neighbouring logic: a single-cycle alarm-match pulse, a vector of periodic tick pulses (one per counter roll-over), and a power-fail level from a dedicated pin. The time counters, the alarm comparison and the tick generation live outside. A processor reaches the block through a small register interface: chip select, read and write strobes, an address and a page bit held inside the status register.

Each source latches into a status bit. The periodic bit and the alarm bit are cleared by writing a one to them. The power-fail bit cannot be cleared by software and follows the pin back to zero once power returns. Enables decide which latched bits reach a pin. The alarm can be steered to either pin. A summary bit in the status register reads 1 while either pin is active. The power-fail request is blocked while chip select is high, so a failing supply cannot cut off a bus access that is already in progress.

Two small state machines carry the state. Each clearable flag has the states FLAG_IDLE and FLAG_PENDING. It moves FLAG_IDLE to FLAG_PENDING on its set pulse. It moves FLAG_PENDING to FLAG_IDLE on a write-one clear, unless a set pulse arrives in the same cycle. The power-fail tracker has three states:
- PF_CLEAR moves to PF_LATCHED when the synchronised pin shows a failure, power-fail interrupts are enabled and chip select is low.
- PF_CLEAR moves to PF_HELD when the pin shows a failure but the enable or chip select blocks it.
- PF_HELD moves to PF_LATCHED once the block lifts.
- PF_HELD and PF_LATCHED both return to PF_CLEAR when the synchronised pin shows power restored.

Top module: `rtc_irq_hub`

## Requirements
- R1: After reset every register reads 0, `irq_n` and `mfo_n` are 1, and the tracker is in PF_CLEAR.
- R2: Address map. Address 0 is the status register on either page, and its bit 6 is the read/write page bit. Address 3 is the periodic flag register on page 0. On page 1, address 3 holds the periodic enables (bits 5:0), address 4 holds the alarm enable (bit 0) and the power-fail enable (bit 1), and address 2 holds the alarm route (bit 0: 0 selects `irq_n`, 1 selects `mfo_n`). Any other address, or any cycle without `sel` and `rd`, reads 0.
- R3: Tick i sets periodic flag bit i whatever the enables are. Any read or write of the periodic flag register clears all of its flags at the end of that cycle. A tick that arrives in the same cycle as the access still sets its flag.
- R4: Status bit 1 sets on a tick whose periodic enable bit is 1. It stays pending after the enables are cleared, until a 1 is written to status bit 1.
- R5: Status bit 3 sets on an alarm pulse whether or not the alarm is enabled, and is cleared by writing a 1 to status bit 3.
- R6: Writing 0 to status bit 1 or bit 3 leaves it unchanged. When a set pulse and a clearing write fall in the same cycle, the bit stays set.
- R7: The power-fail pin passes through `SYNC_STAGES` flops. Status bit 4 sets only while the power-fail enable is 1 and `sel` is 0. While `sel` is held high, a failure never sets it.
- R8: Writes do not clear status bit 4. It clears once the synchronised pin shows that power is restored.
- R9: `irq_n` is low while status bit 1 or bit 4 is set, or while status bit 3 is set with the alarm enabled and routed to 0. `mfo_n` is low only while status bit 3 is set with the alarm enabled and routed to 1.
- R10: With every enable at 0, alarm and tick events drive neither pin, yet status bit 3 and the periodic flags still update and can be polled.
- R11: Status bit 0 reads 1 exactly when `irq_n` or `mfo_n` is low.
- R12: Status bits 2, 5 and 7 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Chip select, active high |
| rd | input | 1 | Read strobe, data returned in the same cycle |
| wr | input | 1 | Write strobe, applied at the rising edge |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when no read is selected |
| alarm_hit | input | 1 | Alarm-match pulse |
| tick | input | NUM_TICKS | Periodic roll-over pulses |
| pwr_fail | input | 1 | Power-fail level, 1 while the supply has failed |
| irq_n | output | 1 | Main interrupt pin, active low |
| mfo_n | output | 1 | Alternate interrupt pin, active low |

## Verification
A flag stuck in FLAG_PENDING shows as an interrupt pin held low in the cycle after the clearing write, and the summary bit reads wrongly in the same read. A power-fail tracker that ignores chip select drives `irq_n` low within one edge after the synchronised pin, even while a read is held. One that fails to leave PF_LATCHED keeps `irq_n` low past the synchroniser delay after the pin is released. Routing or enable faults show at once on the wrong pin, one edge after the source pulse.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

    localparam int DATA_W = 8;

    // register addresses
    localparam int ADR_STATUS = 0;
    localparam int ADR_MODE   = 2;
    localparam int ADR_PAGED3 = 3;
    localparam int ADR_ENA1   = 4;

    // status register bit positions
    localparam int ST_SUM  = 0;
    localparam int ST_PER  = 1;
    localparam int ST_ALM  = 3;
    localparam int ST_PF   = 4;
    localparam int ST_PAGE = 6;

    // enable register 1 bit positions
    localparam int EN_ALM = 0;
    localparam int EN_PF  = 1;

    typedef enum logic [1:0] {
        PF_CLEAR   = 2'd0,
        PF_HELD    = 2'd1,
        PF_LATCHED = 2'd2
    } pf_state_e;

    typedef enum logic {
        FLAG_IDLE    = 1'b0,
        FLAG_PENDING = 1'b1
    } flag_state_e;

endpackage

// File: rtl/rtc_irq_w1c_flag.sv
module rtc_irq_w1c_flag
    import rtc_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);

    flag_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE:    if (set_i)           state_d = FLAG_PENDING;
            FLAG_PENDING: if (clr_i && !set_i) state_d = FLAG_IDLE;
            default:                           state_d = FLAG_IDLE;
        endcase
    end

    always_comb begin
        pend_o = (state_q == FLAG_PENDING);
    end

endmodule

// File: rtl/rtc_irq_pf_fsm.sv
module rtc_irq_pf_fsm
    import rtc_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic bus_sel_i,
    input  logic enable_i,
    output logic fail_sync_o,
    output logic pf_stat_o
);

    logic      fail_s;
    pf_state_e state_q, state_d;
    logic      gate_open;

    generate
        if (SYNC_STAGES == 0) begin : g_nosync
            assign fail_s = pin_i;
        end else begin : g_sync
            logic [SYNC_STAGES-1:0] sh_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= '0;
                else        sh_q <= {sh_q[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0 : 0], pin_i} ;
            end
            assign fail_s = sh_q[SYNC_STAGES-1];
        end
    endgenerate

    assign gate_open = enable_i && !bus_sel_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PF_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PF_CLEAR: begin
                if (fail_s) state_d = gate_open ? PF_LATCHED : PF_HELD;
            end
            PF_HELD: begin
                if (!fail_s)        state_d = PF_CLEAR;
                else if (gate_open) state_d = PF_LATCHED;
            end
            PF_LATCHED: begin
                if (!fail_s) state_d = PF_CLEAR;
            end
            default: state_d = PF_CLEAR;
        endcase
    end

    always_comb begin
        pf_stat_o   = (state_q == PF_LATCHED);
        fail_sync_o = fail_s;
    end

endmodule

// File: rtl/rtc_irq_regs.sv
module rtc_irq_regs
    import rtc_irq_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int NUM_TICKS = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel,
    input  logic                 rd,
    input  logic                 wr,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [NUM_TICKS-1:0] tick,
    input  logic                 stat_per,
    input  logic                 stat_alm,
    input  logic                 stat_pf,
    input  logic                 stat_sum,
    output logic [DATA_W-1:0]    rdata,
    output logic                 status_wr,
    output logic [NUM_TICKS-1:0] per_en,
    output logic                 alarm_en,
    output logic                 pf_en,
    output logic                 alarm_route
);

    localparam int PAD_W = DATA_W - NUM_TICKS;

    logic                 page_q;
    logic [NUM_TICKS-1:0] per_en_q;
    logic                 alarm_en_q, pf_en_q, route_q;
    logic [NUM_TICKS-1:0] pflag_q;

    logic hit_st, hit_pflag, hit_ena0, hit_ena1, hit_mode;
    logic acc;

    assign acc       = sel && (rd || wr);
    assign hit_st    = (addr == ADDR_W'(ADR_STATUS));
    assign hit_pflag = (addr == ADDR_W'(ADR_PAGED3)) && !page_q;
    assign hit_ena0  = (addr == ADDR_W'(ADR_PAGED3)) &&  page_q;
    assign hit_ena1  = (addr == ADDR_W'(ADR_ENA1))   &&  page_q;
    assign hit_mode  = (addr == ADDR_W'(ADR_MODE))   &&  page_q;

    assign status_wr = sel && wr && hit_st;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q     <= 1'b0;
            per_en_q   <= '0;
            alarm_en_q <= 1'b0;
            pf_en_q    <= 1'b0;
            route_q    <= 1'b0;
        end else if (sel && wr) begin
            if (hit_st)   page_q <= wdata[ST_PAGE];
            if (hit_ena0) per_en_q <= wdata[NUM_TICKS-1:0];
            if (hit_ena1) begin
                alarm_en_q <= wdata[EN_ALM];
                pf_en_q    <= wdata[EN_PF];
            end
            if (hit_mode) route_q <= wdata[0];
        end
    end

    generate
        for (genvar i = 0; i < NUM_TICKS; i++) begin : g_pflag
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pflag_q[i] <= 1'b0;
                else        pflag_q[i] <= tick[i] || (pflag_q[i] && !(acc && hit_pflag));
            end
        end
    endgenerate

    always_comb begin
        rdata = '0;
        if (sel && rd) begin
            if (hit_st) begin
                rdata[ST_SUM]  = stat_sum;
                rdata[ST_PER]  = stat_per;
                rdata[ST_ALM]  = stat_alm;
                rdata[ST_PF]   = stat_pf;
                rdata[ST_PAGE] = page_q;
            end else if (hit_pflag) begin
                rdata = {{PAD_W{1'b0}}, pflag_q};
            end else if (hit_ena0) begin
                rdata = {{PAD_W{1'b0}}, per_en_q};
            end else if (hit_ena1) begin
                rdata[EN_ALM] = alarm_en_q;
                rdata[EN_PF]  = pf_en_q;
            end else if (hit_mode) begin
                rdata[0] = route_q;
            end
        end
    end

    assign per_en      = per_en_q;
    assign alarm_en    = alarm_en_q;
    assign pf_en       = pf_en_q;
    assign alarm_route = route_q;

endmodule

// File: rtl/rtc_irq_hub.sv
module rtc_irq_hub
    import rtc_irq_pkg::*;
#(
    parameter int ADDR_W      = 5,
    parameter int NUM_TICKS   = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel,
    input  logic                 rd,
    input  logic                 wr,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [7:0]           wdata,
    output logic [7:0]           rdata,
    input  logic                 alarm_hit,
    input  logic [NUM_TICKS-1:0] tick,
    input  logic                 pwr_fail,
    output logic                 irq_n,
    output logic                 mfo_n
);

    logic                 status_wr;
    logic [NUM_TICKS-1:0] per_en;
    logic                 alarm_en, pf_en, alarm_route;
    logic                 per_stat, alm_stat, pf_stat, pf_sync;
    logic                 irq_act, mfo_act, sum_act;

    rtc_irq_regs #(.ADDR_W(ADDR_W), .NUM_TICKS(NUM_TICKS)) u_regs (
        .clk(clk), .rst_n(rst_n), .sel(sel), .rd(rd), .wr(wr),
        .addr(addr), .wdata(wdata), .tick(tick),
        .stat_per(per_stat), .stat_alm(alm_stat), .stat_pf(pf_stat),
        .stat_sum(sum_act), .rdata(rdata), .status_wr(status_wr),
        .per_en(per_en), .alarm_en(alarm_en), .pf_en(pf_en),
        .alarm_route(alarm_route)
    );

    rtc_irq_w1c_flag u_per_flag (
        .clk(clk), .rst_n(rst_n),
        .set_i(|(tick & per_en)),
        .clr_i(status_wr && wdata[ST_PER]),
        .pend_o(per_stat)
    );

    rtc_irq_w1c_flag u_alm_flag (
        .clk(clk), .rst_n(rst_n),
        .set_i(alarm_hit),
        .clr_i(status_wr && wdata[ST_ALM]),
        .pend_o(alm_stat)
    );

    rtc_irq_pf_fsm #(.SYNC_STAGES(SYNC_STAGES)) u_pf (
        .clk(clk), .rst_n(rst_n), .pin_i(pwr_fail), .bus_sel_i(sel),
        .enable_i(pf_en), .fail_sync_o(pf_sync), .pf_stat_o(pf_stat)
    );

    always_comb begin
        irq_act = per_stat || pf_stat || (alm_stat && alarm_en && !alarm_route);
        mfo_act = alm_stat && alarm_en && alarm_route;
        sum_act = irq_act || mfo_act;
        irq_n   = !irq_act;
        mfo_n   = !mfo_act;
    end

endmodule

// File: rtl/rtc_irq_hub_chk.sv
module rtc_irq_hub_chk #(
    parameter int ADDR_W    = 5,
    parameter int NUM_TICKS = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sel,
    input logic                 rd,
    input logic                 wr,
    input logic [ADDR_W-1:0]    addr,
    input logic [7:0]           wdata,
    input logic [7:0]           rdata,
    input logic                 alarm_hit,
    input logic                 irq_n,
    input logic                 mfo_n,
    input logic [NUM_TICKS-1:0] per_en,
    input logic                 alarm_en,
    input logic                 alarm_route,
    input logic                 pf_en,
    input logic                 per_stat,
    input logic                 alm_stat,
    input logic                 pf_stat,
    input logic                 pf_sync
);

    logic st_read, st_write;
    assign st_read  = sel && rd && (addr == '0);
    assign st_write = sel && wr && (addr == '0);

    assert_summary_R11: assert property (@(posedge clk) disable iff (!rst_n)
        st_read |-> (rdata[0] == (!irq_n || !mfo_n)));

    assert_reserved_R12: assert property (@(posedge clk) disable iff (!rst_n)
        st_read |-> (rdata[7] == 1'b0 && rdata[5] == 1'b0 && rdata[2] == 1'b0));

    assert_mfo_route_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !mfo_n |-> (alarm_route && alarm_en && alm_stat));

    assert_pf_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pf_stat) |-> ($past(!sel) && $past(pf_en)));

    assert_pf_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_stat && pf_sync) |=> pf_stat);

    assert_w1c_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (alm_stat && !(st_write && wdata[3])) |=> alm_stat);

    assert_alarm_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit |=> alm_stat);

    assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (per_en == '0 && !alarm_en && !pf_en && !per_stat && !pf_stat) |-> (irq_n && mfo_n));

endmodule

bind rtc_irq_hub rtc_irq_hub_chk #(.ADDR_W(ADDR_W), .NUM_TICKS(NUM_TICKS)) u_chk (
    .clk(clk), .rst_n(rst_n), .sel(sel), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .alarm_hit(alarm_hit), .irq_n(irq_n), .mfo_n(mfo_n),
    .per_en(per_en), .alarm_en(alarm_en), .alarm_route(alarm_route), .pf_en(pf_en),
    .per_stat(per_stat), .alm_stat(alm_stat), .pf_stat(pf_stat), .pf_sync(pf_sync)
);

// File: tb/tb_rtc_irq_hub.sv
`timescale 1ns/1ps
module tb_rtc_irq_hub;

    localparam int AW = 5;
    localparam int NT = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel = 0, rd = 0, wr = 0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rdata;
    logic          alarm_hit = 0;
    logic [NT-1:0] tick = '0;
    logic          pwr_fail = 0;
    logic          irq_n, mfo_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    rtc_irq_hub #(.ADDR_W(AW), .NUM_TICKS(NT), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .rd(rd), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata), .alarm_hit(alarm_hit), .tick(tick),
        .pwr_fail(pwr_fail), .irq_n(irq_n), .mfo_n(mfo_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bwrite(input int a, input int d);
        @(negedge clk);
        sel = 1; wr = 1; addr = AW'(a); wdata = 8'(d);
        @(negedge clk);
        sel = 0; wr = 0;
    endtask

    task automatic bread(input int a, output int d);
        @(negedge clk);
        sel = 1; rd = 1; addr = AW'(a);
        #1 d = int'(rdata);
        @(negedge clk);
        sel = 0; rd = 0;
    endtask

    task automatic pulse_alarm();
        @(negedge clk); alarm_hit = 1;
        @(negedge clk); alarm_hit = 0;
    endtask

    task automatic pulse_tick(input int i);
        @(negedge clk); tick[i] = 1'b1;
        @(negedge clk); tick = '0;
    endtask

    task automatic pins(input string req, input int ei, input int em);
        chk(req, int'(irq_n), ei);
        chk(req, int'(mfo_n), em);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        pins("R1 pins", 1, 1);
        bread(0, d); chk("R1 status", d, 0);
        bread(3, d); chk("R1 pflag", d, 0);
        bwrite(0, 8'h40);
        bread(0, d); chk("R2 page bit readback", d, 8'h40);
        bread(3, d); chk("R1 ena0", d, 0);
        bread(4, d); chk("R1 ena1", d, 0);
        bread(2, d); chk("R1 mode", d, 0);
        bwrite(0, 8'h00);

        // R10 no enables: events latch but no pin activity
        pulse_alarm(); pulse_tick(0);
        pins("R10 quiet pins", 1, 1);
        bread(0, d); chk("R10 status polled", d, 8'h08);
        bread(3, d); chk("R10 pflag polled", d, 8'h01);
        bread(3, d); chk("R3 pflag cleared by read", d, 0);

        // R6 write zero leaves alarm set; R5 w1c clears
        bwrite(0, 8'h00);
        bread(0, d); chk("R6 write zero keeps bit3", d & 8'h08, 8'h08);
        bwrite(0, 8'h08);
        bread(0, d); chk("R5 w1c clears bit3", d, 0);

        // R6 same-cycle set and clear
        @(negedge clk);
        alarm_hit = 1; sel = 1; wr = 1; addr = 0; wdata = 8'h08;
        @(negedge clk);
        alarm_hit = 0; sel = 0; wr = 0;
        bread(0, d); chk("R6 set wins over clear", d & 8'h08, 8'h08);
        bwrite(0, 8'h08);

        // R2 address map details
        bwrite(0, 8'h40);
        bwrite(3, 8'h2a); bwrite(4, 8'h01); bwrite(2, 8'h01);
        bread(3, d); chk("R2 ena0 page1", d, 8'h2a);
        bread(4, d); chk("R2 ena1 page1", d, 8'h01);
        bread(2, d); chk("R2 mode page1", d, 8'h01);
        bread(7, d); chk("R2 unmapped", d, 0);
        @(negedge clk); sel = 0; rd = 1; addr = 3; #1 chk("R2 no select", int'(rdata), 0);
        @(negedge clk); rd = 0;
        bwrite(0, 8'h00);
        bread(3, d); chk("R2 pflag page0", d, 0);
        bread(0, d); chk("R2 status on page0", d, 0);

        // R9 alarm routing sweep
        for (int en = 0; en < 2; en++) begin
            for (int rt = 0; rt < 2; rt++) begin
                bwrite(0, 8'h40);
                bwrite(4, en); bwrite(2, rt);
                pulse_alarm();
                pins("R9 alarm route", (en && !rt) ? 0 : 1, (en && rt) ? 0 : 1);
                bread(0, d);
                chk("R11 summary with alarm", d & 8'h01, en);
                chk("R12 reserved bits", d & 8'ha4, 0);
                bwrite(0, 8'h48);
                pins("R5 alarm cleared pins", 1, 1);
                bread(0, d); chk("R5 alarm bit clear", d & 8'h08, 0);
            end
        end
        bwrite(4, 0); bwrite(2, 0);

        // R3/R4 periodic sweep over all masks and ticks
        for (int m = 0; m < 64; m++) begin
            bwrite(0, 8'h40); bwrite(3, m); bwrite(0, 8'h00);
            for (int i = 0; i < NT; i++) begin
                pulse_tick(i);
                chk("R4 periodic irq", int'(irq_n), m[i] ? 0 : 1);
                bread(3, d); chk("R3 pflag set", d, 1 << i);
                bread(3, d); chk("R3 pflag cleared", d, 0);
                bread(0, d); chk("R4 status bit1", d & 8'h03, m[i] ? 3 : 0);
                bwrite(0, 8'h02);
                chk("R4 w1c periodic", int'(irq_n), 1);
            end
        end

        // R4 pending survives disable
        bwrite(0, 8'h40); bwrite(3, 8'h01); bwrite(0, 8'h00);
        pulse_tick(0);
        bwrite(0, 8'h40); bwrite(3, 8'h00);
        chk("R4 pending after disable", int'(irq_n), 0);
        bwrite(0, 8'h42);
        chk("R4 cleared after disable", int'(irq_n), 1);
        bwrite(0, 8'h00);

        // R3 tick during access still sets
        @(negedge clk);
        sel = 1; rd = 1; addr = 3; tick[2] = 1'b1;
        @(negedge clk);
        sel = 0; rd = 0; tick = '0;
        bread(3, d); chk("R3 tick wins over access clear", d, 8'h04);

        // R7 power fail disabled: never sets
        pwr_fail = 1;
        repeat (6) @(negedge clk);
        chk("R7 pf disabled irq", int'(irq_n), 1);
        bread(0, d); chk("R7 pf disabled status", d & 8'h10, 0);
        pwr_fail = 0;
        repeat (4) @(negedge clk);

        // R7 blocked while sel high
        bwrite(0, 8'h40); bwrite(4, 8'h02);
        @(negedge clk);
        sel = 1; rd = 1; addr = 0;
        pwr_fail = 1;
        repeat (8) @(negedge clk);
        #1;
        chk("R7 pf blocked by select status", int'(rdata) & 8'h10, 0);
        chk("R7 pf blocked by select irq", int'(irq_n), 1);
        sel = 0; rd = 0;
        repeat (2) @(negedge clk);
        chk("R7 pf latched after select drops", int'(irq_n), 0);
        bread(0, d); chk("R7 pf status and summary", d, 8'h51);

        // R8 not cleared by write; clears on power return
        bwrite(0, 8'h5a);
        bread(0, d); chk("R8 pf survives write", d & 8'h10, 8'h10);
        chk("R8 irq still low", int'(irq_n), 0);
        pwr_fail = 0;
        repeat (5) @(negedge clk);
        chk("R8 irq released", int'(irq_n), 1);
        bread(0, d); chk("R8 pf status cleared", d, 8'h40);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule